// File: doc/BRIEF.md
# Carry-Save Counter-Row Multiplier Core

This core multiplies two 6-bit unsigned operands without performing the final carry-propagate addition. It leaves the result as two vectors. The wide vector `p_o` spans weights 2^0 to 2^10. The narrow vector `q_o` spans weights 2^5 to 2^10. Their sum is the product. A larger multiplier can take the two vectors and merge them in its own reduction tree, together with results from neighbouring cores.

Each of the eleven weight columns of the partial-product matrix has its own counter. A counter adds the AND terms of its column to the carry count handed up from the column below. It keeps a small remainder locally and passes the rest upward as a binary count.

The six least significant columns keep one bit each. The low six bits of `p_o` therefore already equal the low six bits of the product. The five upper columns may keep two bits each, one on `p_o` and one on `q_o`. Bit 5 of `q_o` has no source and is tied to zero. The block is purely combinational.

Top module: `cs_borrow_mul`

## Requirements
- R1: For every operand pair, the value of `p_o` plus the value of `q_o` multiplied by 32 equals the unsigned product `a_i * b_i`.
- R2: `p_o[5:0]` equals bits 5 down to 0 of the product. No part of these weights is left in redundant form.
- R3: The top column never needs a carry beyond weight 2^10. For `a_i = b_i = 63`, the outputs are `p_o = 1985` (binary 11111000001) and `q_o = 6'b111110`.
- R4: `q_o[5]` (weight 2^5) is zero for every operand pair.
- R5: When either operand is zero, both `p_o` and `q_o` are zero.
- R6: When `b_i = 1`, `p_o` equals `a_i` and `q_o` is zero.
- R7: At any weight from 2^6 to 2^10, a set bit in `q_o` implies that the `p_o` bit of the same weight is set.
- R8: Exchanging `a_i` and `b_i` leaves both `p_o` and `q_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 6 | Multiplicand, unsigned |
| b_i | input | 6 | Multiplier, unsigned |
| p_o | output | 11 | Primary result vector, weights 2^0 to 2^10 |
| q_o | output | 6 | Secondary result vector, indexed [10:5], weights 2^5 to 2^10 |

## Verification
The hardest situation to reach is the one where every column is full at once. In that case the carry count climbing through the upper columns is at its largest, and the top column has to absorb exactly two units without spilling past weight 2^10. Only a few operand pairs with all high bits set come close to this. The stimulus therefore walks the complete 64 by 64 operand space and adds directed all-ones and single-one patterns. Randomly drawn pairs from a fixed seed are applied in both operand orders to expose any asymmetry in how the columns are formed.

// File: rtl/bcm_pkg.sv
`timescale 1ns/1ps
package bcm_pkg;

    parameter int unsigned OPW = 6;

    typedef enum logic {
        SLOT_SINGLE = 1'b0,
        SLOT_PAIR   = 1'b1
    } slot_mode_e;

    function automatic int unsigned col_height(int unsigned w, int unsigned k);
        return (k < w) ? k + 1 : 2 * w - 1 - k;
    endfunction

    function automatic int unsigned carry_bits(int unsigned w);
        return $clog2(2 * w);
    endfunction

endpackage

// File: rtl/bcm_ppgen.sv
`timescale 1ns/1ps
module bcm_ppgen #(
    parameter  int unsigned W    = bcm_pkg::OPW,
    localparam int unsigned NCOL = 2 * W - 1
) (
    input  logic [W-1:0]            mcand_i,
    input  logic [W-1:0]            mplier_i,
    output logic [NCOL-1:0][W-1:0]  col_o
);

    for (genvar k = 0; k < NCOL; k++) begin : g_col
        for (genvar s = 0; s < W; s++) begin : g_row
            if ((k >= s) && (k - s < W)) begin : g_live
                assign col_o[k][s] = mcand_i[k-s] & mplier_i[s];
            end else begin : g_pad
                assign col_o[k][s] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/bcm_col_counter.sv
`timescale 1ns/1ps
module bcm_col_counter #(
    parameter  int unsigned          H     = bcm_pkg::OPW,
    parameter  int unsigned          CW    = 4,
    parameter  bcm_pkg::slot_mode_e  MODE  = bcm_pkg::SLOT_SINGLE,
    localparam int unsigned          NSLOT = (MODE == bcm_pkg::SLOT_PAIR) ? 2 : 1
) (
    input  logic [H-1:0]      bits_i,
    input  logic [CW-1:0]     cin_i,
    output logic [NSLOT-1:0]  keep_o,
    output logic [CW-1:0]     cout_o
);

    localparam int unsigned TW = CW + 1;

    logic [TW-1:0] total;

    always_comb begin
        total = TW'(cin_i);
        for (int i = 0; i < H; i++) begin
            total = total + TW'(bits_i[i]);
        end
    end

    if (MODE == bcm_pkg::SLOT_PAIR) begin : g_pair
        logic [TW-1:0] less_one;
        always_comb begin
            less_one = total - TW'(1);
            if (total == '0) begin
                keep_o = 2'b00;
                cout_o = '0;
            end else begin
                keep_o = {less_one[0], 1'b1};
                cout_o = less_one[TW-1:1];
            end
        end
    end else begin : g_single
        always_comb begin
            keep_o = total[0];
            cout_o = total[TW-1:1];
        end
    end

endmodule

// File: rtl/cs_borrow_mul.sv
`timescale 1ns/1ps
module cs_borrow_mul #(
    parameter  int unsigned W    = bcm_pkg::OPW,
    localparam int unsigned NCOL = 2 * W - 1,
    localparam int unsigned CW   = bcm_pkg::carry_bits(W)
) (
    input  logic [W-1:0]        a_i,
    input  logic [W-1:0]        b_i,
    output logic [NCOL-1:0]     p_o,
    output logic [NCOL-1:W-1]   q_o
);

    logic [NCOL-1:0][W-1:0] cols;
    logic [CW-1:0]          carry [NCOL+1];

    bcm_ppgen #(.W(W)) u_pp (
        .mcand_i  (a_i),
        .mplier_i (b_i),
        .col_o    (cols)
    );

    assign carry[0]   = '0;
    assign q_o[W-1]   = 1'b0;

    for (genvar k = 0; k < NCOL; k++) begin : g_cnt
        if (k < W) begin : g_res
            logic [0:0] kv;
            bcm_col_counter #(
                .H(W), .CW(CW), .MODE(bcm_pkg::SLOT_SINGLE)
            ) u_col (
                .bits_i (cols[k]),
                .cin_i  (carry[k]),
                .keep_o (kv),
                .cout_o (carry[k+1])
            );
            assign p_o[k] = kv[0];
        end else begin : g_red
            logic [1:0] kv;
            bcm_col_counter #(
                .H(W), .CW(CW), .MODE(bcm_pkg::SLOT_PAIR)
            ) u_col (
                .bits_i (cols[k]),
                .cin_i  (carry[k]),
                .keep_o (kv),
                .cout_o (carry[k+1])
            );
            assign p_o[k] = kv[0];
            assign q_o[k] = kv[1];
        end
    end

endmodule

module cs_borrow_mul_chk #(
    parameter  int unsigned W    = bcm_pkg::OPW,
    localparam int unsigned NCOL = 2 * W - 1,
    localparam int unsigned CW   = bcm_pkg::carry_bits(W),
    localparam int unsigned PW   = 2 * W
) (
    input logic [W-1:0]       a_i,
    input logic [W-1:0]       b_i,
    input logic [NCOL-1:0]    p_o,
    input logic [NCOL-1:W-1]  q_o,
    input logic [CW-1:0]      top_carry_i
);

    logic [PW-1:0] prod;
    logic [PW-1:0] recon;

    assign prod  = PW'(a_i) * PW'(b_i);
    assign recon = PW'(p_o) + (PW'(q_o) << (W - 1));

    always_comb begin
        p_exact_product_r1: assert (recon == prod)
            else $error("R1 sum of result vectors differs from product");
        p_low_resolved_r2: assert (p_o[W-1:0] == prod[W-1:0])
            else $error("R2 low bits not resolved");
        p_no_overflow_r3: assert (top_carry_i == '0)
            else $error("R3 top column spilled a carry");
        p_q_floor_zero_r4: assert (q_o[W-1] == 1'b0)
            else $error("R4 lowest secondary bit set");
        p_zero_operand_r5: assert (!((a_i == '0) || (b_i == '0)) || ((p_o == '0) && (q_o == '0)))
            else $error("R5 zero operand gave nonzero output");
        p_unit_operand_r6: assert (!(b_i == W'(1)) || ((p_o == NCOL'(a_i)) && (q_o == '0)))
            else $error("R6 unit multiplier mismatch");
        p_pair_order_r7: assert ((q_o & ~p_o[NCOL-1:W-1]) == '0)
            else $error("R7 secondary bit without primary bit");
    end

endmodule

bind cs_borrow_mul cs_borrow_mul_chk #(.W(W)) u_chk (
    .a_i         (a_i),
    .b_i         (b_i),
    .p_o         (p_o),
    .q_o         (q_o),
    .top_carry_i (carry[NCOL])
);

// File: tb/cs_borrow_mul_tb.sv
`timescale 1ns/1ps
module cs_borrow_mul_tb;

    localparam int W    = 6;
    localparam int NCOL = 2 * W - 1;

    logic               clk = 1'b0;
    logic [W-1:0]       a = '0;
    logic [W-1:0]       b = '0;
    logic [NCOL-1:0]    p;
    logic [NCOL-1:W-1]  q;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    cs_borrow_mul u_dut (
        .a_i (a),
        .b_i (b),
        .p_o (p),
        .q_o (q)
    );

    function automatic int exp_prod(int x, int y);
        return x * y;
    endfunction

    function automatic int recon_val(int pv, int qv);
        return pv + (qv << (W - 1));
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic apply(int x, int y);
        @(posedge clk);
        a = W'(x);
        b = W'(y);
        @(negedge clk);
    endtask

    task automatic check_core(int x, int y);
        int pr;
        int rc;
        pr = exp_prod(x, y);
        rc = recon_val(int'(p), int'(q));
        check(rc == pr, "R1", rc, pr);
        check(int'(p[W-1:0]) == (pr % 64), "R2", int'(p[W-1:0]), pr % 64);
        check(q[W-1] == 1'b0, "R4", int'(q[W-1]), 0);
        check((q & ~p[NCOL-1:W-1]) == '0, "R7", int'(q & ~p[NCOL-1:W-1]), 0);
    endtask

    initial begin
        int pv;
        int qv;
        @(negedge clk);
        check((p == '0) && (q == '0), "R5", int'(p) + int'(q), 0);

        apply(0, 63);
        check((p == '0) && (q == '0), "R5", int'(p) + int'(q), 0);
        apply(63, 0);
        check((p == '0) && (q == '0), "R5", int'(p) + int'(q), 0);

        for (int x = 0; x < 64; x += 7) begin
            apply(x, 1);
            check((int'(p) == x) && (q == '0), "R6", int'(p), x);
        end

        apply(63, 63);
        check(int'(p) == 1985, "R3", int'(p), 1985);
        check(int'(q) == 62, "R3", int'(q), 62);
        check_core(63, 63);

        apply(32, 32);
        check_core(32, 32);
        apply(33, 62);
        check_core(33, 62);

        for (int x = 0; x < 64; x++) begin
            for (int y = 0; y < 64; y++) begin
                apply(x, y);
                check_core(x, y);
            end
        end

        void'($urandom(32'd5171));
        for (int n = 0; n < 200; n++) begin
            int x;
            int y;
            x = int'($urandom % 64);
            y = int'($urandom % 64);
            apply(x, y);
            pv = int'(p);
            qv = int'(q);
            check_core(x, y);
            apply(y, x);
            check(int'(p) == pv, "R8", int'(p), pv);
            check(int'(q) == qv, "R8", int'(q), qv);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule